// File: doc/BRIEF.md
# Transport Stream Packet Synchronizer

This block sits behind a transport stream front end and recovers packet framing from a raw byte stream. Bytes arrive either on a parallel byte port or, when serial mode is selected, as single bits that the block assembles into bytes most significant bit first. The block hunts for the configured sync value, then checks that it recurs at exactly one packet pitch. Only after a programmable number of consecutive, correctly spaced sync bytes does it declare lock and start forwarding data.

Once locked, every forwarded byte is tagged. A start-of-packet marker sits on each packet's first byte. A start-of-line marker sits on the first byte of every group of a fixed number of whole packets, and a line-complete marker sits on the last byte of such a group. This lets a downstream FIFO or DMA engine move whole lines. A missing sync byte at an expected packet start drops lock at once. The block then searches again.

A single 24-bit control word carries the sync value, the packet length and the required lock count. Some settings are unusable: a lock count of 0 or 5, or a packet length below 2. With any of these the block stays unlocked.

Top module: `ts_pkt_sync`

## Requirements
- R1: The control word holds the sync value in bits 23:16, the packet length in bytes in bits 15:4 and the lock count in bits 3:0. A packet length below 2 holds the block unlocked with no output.
- R2: When `ser_mode` is 1, each `ser_valid` cycle shifts in one bit of `ser_bit`, most significant bit first. Every eighth bit completes one byte. The parallel port is ignored while serial mode is selected.
- R3: Lock is declared on the N-th of N consecutive sync bytes spaced exactly one packet length apart, where N is the lock count. `locked` rises in the same cycle that this sync byte appears at the output. With N=1 the first sync byte locks.
- R4: Lock counts of 0 and 5 are invalid. With either, `locked` stays 0 and no byte is emitted.
- R5: Bytes received before lock are discarded. The first emitted byte after lock is the sync value, with `out_sop` and `out_sol` both 1.
- R6: While locked, a byte other than the sync value at an expected packet start clears `locked`. That byte is not emitted. The search restarts with the following byte.
- R7: `out_sop` is 1 on the first byte of every emitted packet. Emitted packets are grouped into lines of `PKTS_PER_LINE` packets counted from lock. `out_sol` marks the first byte of packet 0 of a line, and `out_eol` marks the last byte of packet `PKTS_PER_LINE-1`.
- R8: In parallel mode, a byte sampled at one rising edge appears on `out_byte` with `out_valid` after the next rising edge. In serial mode this holds counted from the edge that samples the byte's last bit.
- R9: During reset, `out_valid`, `out_sop`, `out_sol`, `out_eol` and `locked` are 0.
- R10: During the lock search, a non-sync byte where the next sync is expected discards the partial count. Lock then needs N fresh consecutive sync bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 24 | Sync value, packet length and lock count |
| ser_mode | input | 1 | 1 selects the serial bit input |
| ser_bit | input | 1 | Serial data bit |
| ser_valid | input | 1 | Serial bit strobe |
| par_byte | input | 8 | Parallel data byte |
| par_valid | input | 1 | Parallel byte strobe |
| out_byte | output | 8 | Forwarded byte |
| out_valid | output | 1 | Forwarded byte strobe |
| out_sop | output | 1 | First byte of a packet |
| out_sol | output | 1 | First byte of a line |
| out_eol | output | 1 | Last byte of a line |
| locked | output | 1 | Packet framing established |

## Verification
A wrong position counter shows up at the next expected packet start. Lock is then lost, or granted on the wrong packet. The scoreboard sees this as an unexpected or missing byte within one packet length. A wrong lock-count comparison makes the first emitted byte arrive one packet early or late, and the first compared byte catches it. A fault in the line counter is only visible at a line edge. For that reason one run emits more than one full line, so that the line-complete marker and the following start-of-line are both compared. Latency faults are caught on every byte, because each expected item carries the cycle in which it must appear.

// File: rtl/ts_pkt_sync_pkg.sv
package ts_pkt_sync_pkg;

   localparam int SYNC_W = 8;
   localparam int LEN_W  = 12;
   localparam int NEED_W = 4;
   localparam int CTRL_W = SYNC_W + LEN_W + NEED_W;

   // packed order places sync in 23:16, length in 15:4, count in 3:0
   typedef struct packed {
      logic [SYNC_W-1:0] sync;
      logic [LEN_W-1:0]  len;
      logic [NEED_W-1:0] need;
   } tsps_cfg_t;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_CHECK = 2'd1,
      ST_LOCK  = 2'd2
   } sync_st_e;

   function automatic logic cfg_usable(input tsps_cfg_t c);
      return (c.need != '0) && (c.need != NEED_W'(5)) && (c.len >= LEN_W'(2));
   endfunction

endpackage

// File: rtl/ts_pkt_sync_deser.sv
module ts_pkt_sync_deser #(
   parameter int BYTE_W    = 8,
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_mode,
   input  logic              ser_bit,
   input  logic              ser_valid,
   input  logic [BYTE_W-1:0] par_byte,
   input  logic              par_valid,
   output logic [BYTE_W-1:0] byte_o,
   output logic              valid_o
);
   localparam int BIT_CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   logic [BYTE_W-1:0] ser_byte;
   logic              ser_done;

   generate
      if (SERIAL_EN) begin : g_serial
         logic [BYTE_W-1:0]    shreg;
         logic [BIT_CNT_W-1:0] bit_cnt;
         logic                 last_bit;

         assign last_bit = (bit_cnt == BIT_CNT_W'(BYTE_W-1));

         always_ff @(posedge clk) begin
            if (!rst_n || !ser_mode) begin
               shreg   <= '0;
               bit_cnt <= '0;
            end else if (ser_valid) begin
               shreg   <= {shreg[BYTE_W-2:0], ser_bit};
               bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
            end
         end

         assign ser_byte = {shreg[BYTE_W-2:0], ser_bit};
         assign ser_done = ser_mode && ser_valid && last_bit;
      end else begin : g_parallel_only
         assign ser_byte = '0;
         assign ser_done = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_o  <= '0;
         valid_o <= 1'b0;
      end else if (ser_mode) begin
         byte_o  <= ser_byte;
         valid_o <= ser_done;
      end else begin
         byte_o  <= par_byte;
         valid_o <= par_valid;
      end
   end

endmodule

// File: rtl/ts_pkt_sync_lock.sv
module ts_pkt_sync_lock
   import ts_pkt_sync_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  tsps_cfg_t         cfg,
   input  logic [SYNC_W-1:0] in_byte,
   input  logic              in_valid,
   output logic              emit_o,
   output logic              start_o,
   output logic              first_o,
   output logic              last_o,
   output logic              lock_o
);
   sync_st_e          st, st_n;
   logic [LEN_W-1:0]  pos, pos_n;
   logic [NEED_W-1:0] hits, hits_n;
   logic              is_sync, at_end, cfg_ok;
   logic [NEED_W-1:0] hits_inc;
   logic [LEN_W-1:0]  pos_adv;

   assign is_sync  = (in_byte == cfg.sync);
   assign at_end   = (pos == cfg.len - 1'b1);
   assign cfg_ok   = cfg_usable(cfg);
   assign hits_inc = hits + 1'b1;
   assign pos_adv  = at_end ? '0 : pos + 1'b1;

   always_comb begin
      st_n    = st;
      pos_n   = pos;
      hits_n  = hits;
      emit_o  = 1'b0;
      start_o = 1'b0;
      first_o = 1'b0;
      last_o  = 1'b0;
      if (!cfg_ok) begin
         st_n   = ST_HUNT;
         pos_n  = '0;
         hits_n = '0;
      end else if (in_valid) begin
         unique case (st)
            ST_HUNT: begin
               if (is_sync) begin
                  pos_n = LEN_W'(1);
                  if (cfg.need == NEED_W'(1)) begin
                     st_n    = ST_LOCK;
                     emit_o  = 1'b1;
                     start_o = 1'b1;
                     first_o = 1'b1;
                  end else begin
                     st_n   = ST_CHECK;
                     hits_n = NEED_W'(1);
                  end
               end
            end
            ST_CHECK: begin
               if (pos == '0) begin
                  if (is_sync) begin
                     pos_n = LEN_W'(1);
                     if (hits_inc == cfg.need) begin
                        st_n    = ST_LOCK;
                        emit_o  = 1'b1;
                        start_o = 1'b1;
                        first_o = 1'b1;
                     end else begin
                        hits_n = hits_inc;
                     end
                  end else begin
                     st_n   = ST_HUNT;
                     pos_n  = '0;
                     hits_n = '0;
                  end
               end else begin
                  pos_n = pos_adv;
               end
            end
            ST_LOCK: begin
               if (pos == '0) begin
                  if (is_sync) begin
                     emit_o  = 1'b1;
                     start_o = 1'b1;
                     pos_n   = LEN_W'(1);
                  end else begin
                     st_n   = ST_HUNT;
                     pos_n  = '0;
                     hits_n = '0;
                  end
               end else begin
                  emit_o = 1'b1;
                  last_o = at_end;
                  pos_n  = pos_adv;
               end
            end
            default: begin
               st_n   = ST_HUNT;
               pos_n  = '0;
               hits_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_HUNT;
         pos  <= '0;
         hits <= '0;
      end else begin
         st   <= st_n;
         pos  <= pos_n;
         hits <= hits_n;
      end
   end

   assign lock_o = (st == ST_LOCK);

endmodule

// File: rtl/ts_pkt_sync_pack.sv
module ts_pkt_sync_pack #(
   parameter int BYTE_W        = 8,
   parameter int PKTS_PER_LINE = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              emit,
   input  logic              start,
   input  logic              first,
   input  logic              last,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_valid,
   output logic              out_sop,
   output logic              out_sol,
   output logic              out_eol
);
   localparam int IDX_W = (PKTS_PER_LINE > 1) ? $clog2(PKTS_PER_LINE) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKTS_PER_LINE - 1);

   logic [IDX_W-1:0] pkt_idx, cur_idx, idx_next;

   generate
      if (PKTS_PER_LINE > 1) begin : g_multi
         assign idx_next = (pkt_idx == IDX_LAST) ? '0 : pkt_idx + 1'b1;
      end else begin : g_single
         assign idx_next = '0;
      end
   endgenerate

   always_comb begin
      if (start) cur_idx = first ? '0 : idx_next;
      else       cur_idx = pkt_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_idx   <= '0;
         out_byte  <= '0;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_sol   <= 1'b0;
         out_eol   <= 1'b0;
      end else begin
         out_valid <= emit;
         out_sop   <= emit && start;
         out_sol   <= emit && start && (cur_idx == '0);
         out_eol   <= emit && last && (cur_idx == IDX_LAST);
         if (emit) begin
            pkt_idx  <= cur_idx;
            out_byte <= in_byte;
         end
      end
   end

endmodule

// File: rtl/ts_pkt_sync.sv
module ts_pkt_sync
   import ts_pkt_sync_pkg::*;
#(
   parameter int PKTS_PER_LINE  = 20,
   parameter int NOM_PKT_LEN    = 188,
   parameter int MAX_LINE_BYTES = 4096,
   parameter bit SERIAL_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              ser_mode,
   input  logic              ser_bit,
   input  logic              ser_valid,
   input  logic [SYNC_W-1:0] par_byte,
   input  logic              par_valid,
   output logic [SYNC_W-1:0] out_byte,
   output logic              out_valid,
   output logic              out_sop,
   output logic              out_sol,
   output logic              out_eol,
   output logic              locked
);
   localparam int NOM_LINE_BYTES = PKTS_PER_LINE * NOM_PKT_LEN;

   generate
      if (PKTS_PER_LINE < 1) begin : g_bad_count
         $error("ts_pkt_sync: PKTS_PER_LINE must be at least 1");
      end
      if ((NOM_LINE_BYTES % 8) != 0 || NOM_LINE_BYTES > MAX_LINE_BYTES) begin : g_bad_line
         $error("ts_pkt_sync: nominal line size must be a multiple of 8 and within the limit");
      end
   endgenerate

   tsps_cfg_t         cfg;
   logic [SYNC_W-1:0] d_byte;
   logic              d_valid;
   logic              emit, start, first, last;

   assign cfg = tsps_cfg_t'(ctrl_word);

   ts_pkt_sync_deser #(
      .BYTE_W   (SYNC_W),
      .SERIAL_EN(SERIAL_EN)
   ) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_mode (ser_mode),
      .ser_bit  (ser_bit),
      .ser_valid(ser_valid),
      .par_byte (par_byte),
      .par_valid(par_valid),
      .byte_o   (d_byte),
      .valid_o  (d_valid)
   );

   ts_pkt_sync_lock u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg),
      .in_byte (d_byte),
      .in_valid(d_valid),
      .emit_o  (emit),
      .start_o (start),
      .first_o (first),
      .last_o  (last),
      .lock_o  (locked)
   );

   ts_pkt_sync_pack #(
      .BYTE_W       (SYNC_W),
      .PKTS_PER_LINE(PKTS_PER_LINE)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_byte  (d_byte),
      .emit     (emit),
      .start    (start),
      .first    (first),
      .last     (last),
      .out_byte (out_byte),
      .out_valid(out_valid),
      .out_sop  (out_sop),
      .out_sol  (out_sol),
      .out_eol  (out_eol)
   );

endmodule

// File: rtl/ts_pkt_sync_chk.sv
module ts_pkt_sync_chk
   import ts_pkt_sync_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic [SYNC_W-1:0] out_byte,
   input logic              out_valid,
   input logic              out_sop,
   input logic              out_sol,
   input logic              out_eol,
   input logic              locked
);
   tsps_cfg_t c;
   logic      bad_cfg;
   assign c       = tsps_cfg_t'(ctrl_word);
   assign bad_cfg = !cfg_usable(c);

   assert_sop_has_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid);
   assert_sol_is_sop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_sol |-> out_sop);
   assert_eol_has_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_eol |-> (out_valid && !out_sop));
   assert_emit_only_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> locked);
   assert_sol_carries_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_sol |-> (out_byte == c.sync));
   assert_lock_with_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (out_valid && out_sol));
   assert_bad_cfg_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_cfg && $past(bad_cfg)) |-> !locked);
   assert_unlock_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> !out_valid);

endmodule

bind ts_pkt_sync ts_pkt_sync_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_word(ctrl_word),
   .out_byte (out_byte),
   .out_valid(out_valid),
   .out_sop  (out_sop),
   .out_sol  (out_sol),
   .out_eol  (out_eol),
   .locked   (locked)
);

// File: tb/ts_pkt_sync_tb.sv
module ts_pkt_sync_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PPL        = 20;
   localparam int WATCHDOG   = 150000;

   typedef struct packed {
      logic [31:0] stamp;
      logic [7:0]  b;
      logic        sop;
      logic        sol;
      logic        eol;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] ctrl_word = '0;
   logic        ser_mode = 1'b0, ser_bit = 1'b0, ser_valid = 1'b0;
   logic [7:0]  par_byte = '0;
   logic        par_valid = 1'b0;
   logic [7:0]  out_byte;
   logic        out_valid, out_sop, out_sol, out_eol, locked;

   int          checks = 0;
   int          errors = 0;
   int unsigned cyc = 0;
   int          cur_len = 8;
   int          exp_pkt = 0;
   string       cur_req = "R9";
   exp_t        q[$];
   exp_t        mon_e;

   ts_pkt_sync #(.PKTS_PER_LINE(PPL)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
      .ser_mode(ser_mode), .ser_bit(ser_bit), .ser_valid(ser_valid),
      .par_byte(par_byte), .par_valid(par_valid),
      .out_byte(out_byte), .out_valid(out_valid), .out_sop(out_sop),
      .out_sol(out_sol), .out_eol(out_eol), .locked(locked)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (cyc == WATCHDOG) begin
         errors++;
         $display("FAIL R8 watchdog: run reached %0d cycles, expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // monitor: pops one expected item per emitted byte
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected byte %h at cycle %0d, expected no output",
                     cur_req, out_byte, cyc);
         end else begin
            mon_e = q.pop_front();
            if (out_byte !== mon_e.b || out_sop !== mon_e.sop || out_sol !== mon_e.sol ||
                out_eol !== mon_e.eol || cyc != mon_e.stamp) begin
               errors++;
               $display("FAIL %s: got %h sop%b sol%b eol%b @%0d, expected %h sop%b sol%b eol%b @%0d",
                        cur_req, out_byte, out_sop, out_sol, out_eol, cyc,
                        mon_e.b, mon_e.sop, mon_e.sol, mon_e.eol, mon_e.stamp);
            end
         end
      end
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         par_valid = 1'b0;
         ser_valid = 1'b0;
      end
   endtask

   // drives one byte; returns the cycle at which it must appear (R8)
   task automatic put_byte(input logic [7:0] b, output int unsigned due);
      if (ser_mode) begin
         for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            par_valid = 1'b0;
            ser_bit   = b[i];
            ser_valid = 1'b1;
         end
      end else begin
         @(negedge clk);
         ser_valid = 1'b0;
         par_byte  = b;
         par_valid = 1'b1;
      end
      due = cyc + 2;
   endtask

   function automatic logic [7:0] payload(input int k);
      return 8'h10 + 8'(k);
   endfunction

   task automatic send_pkt(input logic [7:0] first_b, input bit emit, input bit restart);
      int unsigned due;
      exp_t e;
      for (int k = 0; k < cur_len; k++) begin
         put_byte((k == 0) ? first_b : payload(k), due);
         if (emit) begin
            if (k == 0) exp_pkt = restart ? 0 : (exp_pkt + 1) % PPL;
            e.stamp = due;
            e.b     = (k == 0) ? first_b : payload(k);
            e.sop   = (k == 0);
            e.sol   = (k == 0) && (exp_pkt == 0);
            e.eol   = (k == cur_len - 1) && (exp_pkt == PPL - 1);
            q.push_back(e);
         end
      end
   endtask

   task automatic lone_byte(input logic [7:0] b);
      int unsigned due;
      put_byte(b, due);
   endtask

   task automatic restart(input logic [7:0] s, input int len, input int need, input logic ser);
      idle(1);
      rst_n     = 1'b0;
      ctrl_word = {s, 12'(len), 4'(need)};
      ser_mode  = ser;
      cur_len   = len;
      idle(3);
      rst_n = 1'b1;
   endtask

   task automatic drain(input string req);
      idle(4);
      chk(q.size() == 0, req, "expected bytes left unseen", q.size(), 0);
      q.delete();
   endtask

   initial begin
      // R9: reset state
      ctrl_word = {8'h47, 12'd8, 4'd3};
      idle(3);
      chk({out_valid, out_sop, out_sol, out_eol, locked} == 5'b0, "R9",
          "outputs during reset", {out_valid, out_sop, out_sol, out_eol, locked}, 0);
      rst_n = 1'b1;

      // R3 R5 R7 R8: parallel lock on third packet, more than one line
      cur_req = "R3 R5 R7 R8";
      restart(8'h47, 8, 3, 1'b0);
      lone_byte(8'h11); lone_byte(8'h22); lone_byte(8'h33); lone_byte(8'h55);
      send_pkt(8'h47, 0, 0);
      send_pkt(8'h47, 0, 0);
      idle(3);
      chk(locked == 1'b0, "R3", "locked after two of three packets", locked, 0);
      send_pkt(8'h47, 1, 1);
      idle(3);
      chk(locked == 1'b1, "R3", "locked after third packet", locked, 1);
      for (int p = 0; p < 22; p++) send_pkt(8'h47, 1, 0);
      drain("R7");

      // R6: bad byte at expected start drops lock; search restarts next byte
      cur_req = "R6";
      lone_byte(8'h00);
      idle(3);
      chk(locked == 1'b0, "R6", "locked after missing sync", locked, 0);
      send_pkt(8'h47, 0, 0);
      send_pkt(8'h47, 0, 0);
      send_pkt(8'h47, 1, 1);
      send_pkt(8'h47, 1, 0);
      drain("R6");
      chk(locked == 1'b1, "R6", "relocked after three fresh packets", locked, 1);

      // R10: broken spacing during search discards partial count
      cur_req = "R10";
      restart(8'h47, 8, 3, 1'b0);
      send_pkt(8'h47, 0, 0);
      send_pkt(8'h47, 0, 0);
      send_pkt(8'h12, 0, 0);
      send_pkt(8'h47, 0, 0);
      send_pkt(8'h47, 0, 0);
      idle(3);
      chk(locked == 1'b0, "R10", "locked before fresh count complete", locked, 0);
      send_pkt(8'h47, 1, 1);
      drain("R10");

      // R4: lock counts 5 and 0 never lock
      cur_req = "R4";
      restart(8'h47, 8, 5, 1'b0);
      for (int p = 0; p < 8; p++) send_pkt(8'h47, 0, 0);
      idle(3);
      chk(locked == 1'b0, "R4", "locked with count 5", locked, 0);
      restart(8'h47, 8, 0, 1'b0);
      for (int p = 0; p < 4; p++) send_pkt(8'h47, 0, 0);
      idle(3);
      chk(locked == 1'b0, "R4", "locked with count 0", locked, 0);
      drain("R4");

      // R1: length 1 invalid; other sync value and length decoded from fields
      cur_req = "R1";
      restart(8'h47, 1, 2, 1'b0);
      for (int p = 0; p < 10; p++) lone_byte(8'h47);
      idle(3);
      chk(locked == 1'b0, "R1", "locked with packet length 1", locked, 0);
      restart(8'hB8, 12, 2, 1'b0);
      lone_byte(8'h47); lone_byte(8'h47); lone_byte(8'h01);
      send_pkt(8'hB8, 0, 0);
      send_pkt(8'hB8, 1, 1);
      send_pkt(8'hB8, 1, 0);
      drain("R1");

      // R3: count 1 locks on the first sync byte
      cur_req = "R3";
      restart(8'h47, 8, 1, 1'b0);
      lone_byte(8'h99);
      send_pkt(8'h47, 1, 1);
      send_pkt(8'h47, 1, 0);
      drain("R3");

      // R2: serial input, MSB first, parallel port ignored
      cur_req = "R2";
      restart(8'h47, 8, 2, 1'b1);
      par_byte = 8'h47;
      lone_byte(8'h5A);
      send_pkt(8'h47, 0, 0);
      send_pkt(8'h47, 1, 1);
      send_pkt(8'h47, 1, 0);
      drain("R2");
      chk(locked == 1'b1, "R2", "locked in serial mode", locked, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule